// File: doc/BRIEF.md
# Crossbar PUF Phase Sequencer

This controller steps a resistive-crossbar challenge-response token through its operating phases. The analog array, the column comparators and the switching sensor are outside the block. The block emits a two-bit drive code for the left-side and the right-side multiplexer of every row. It times each pulse in clock cycles and strobes the column sample-and-hold. It also captures the comparator bits into a response register. It runs four operations:

- a challenge-response run, which always starts with a refresh pass and ends with a boundary-measurement cycle;
- an off-state characterization of one selected cell;
- an on-state characterization of one selected cell;
- a switch-on-time measurement of one selected cell.

The comparator reference code and the sample delay are not fixed. They are read from a table indexed by a 2-bit supply-voltage bin and a 2-bit temperature bin. Both values are captured when a run starts.

A run is launched with a one-cycle `start_i` while the block is idle. `busy_o` stays high until the run ends. `done_o` then pulses for one cycle. Pulse lengths come from the `t_*_i` inputs, which are held in registers at start.

Top module: `crossbar_phase_seq`

## Requirements
- R1: In a challenge-response run (op 0), the cycles that follow the start are a refresh window of `t_long_i` cycles with phase code 1. In this window every left code is float (00) and every right code is negative (10). This window always comes before the challenge window.
- R2: The challenge window (phase code 2) lasts `t_chal_i` cycles. Row r's left code is positive (01) when challenge bit r is 1 and float when it is 0. All right codes are float.
- R3: Characterization ops (phase code 3) drive only the selected row's left side; every other code is float. Op 1 applies negative for `t_long_i` cycles and then positive for `t_probe_i` cycles. Op 2 applies positive and then negative.
- R4: For ops 0 to 2, `sample_o` is high for exactly one cycle. This is cycle min(dly, len-1) of the second pulse, counted from 0. The response register takes the comparator bits at that cycle and holds its value at all other times, op 3 included.
- R5: At start, `iref_code_o` loads 16 + 12*(4*v + t) and the sample delay becomes v + 2*t, where v = `volt_bin_i` and t = `temp_bin_i`.
- R6: An op 0 run ends with one cycle of phase code 4 with `measure_o` high and all codes float. Ops 1 to 3 have no such cycle.
- R7: Op 3 applies negative to the selected row for `t_long_i` cycles and then positive until `switched_i` is seen. `ton_o` records the number of positive cycles before that cycle, and saturates at 2^TON_W - 1 (15).
- R8: `busy_o` is high in every cycle of a run. In the first idle cycle after it, `done_o` is high for exactly one cycle, with phase code 0 and all codes float.
- R9: A start request while busy is ignored. The schedule, codes and latched challenge are those of the run in progress.
- R10: A programmed duration of 0 behaves as 1 cycle.
- R11: After reset the block is idle: phase 0, all codes float, `busy_o`, `done_o` and `sample_o` low, and response and `ton_o` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch request, taken only when idle |
| op_i | input | 2 | 0 challenge-response, 1 off-state, 2 on-state, 3 switch-on time |
| challenge_i | input | ROWS | One bit per row |
| dev_row_i | input | ROW_W | Row of the cell to characterize |
| t_long_i | input | CNT_W | Long (reset/refresh) pulse cycles |
| t_chal_i | input | CNT_W | Challenge pulse cycles |
| t_probe_i | input | CNT_W | Short probe pulse cycles |
| volt_bin_i | input | 2 | Quantized supply voltage |
| temp_bin_i | input | 2 | Quantized temperature |
| col_cmp_i | input | COLS | Column comparator outputs |
| switched_i | input | 1 | Cell-switched indication |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| phase_o | output | 3 | 0 idle, 1 refresh, 2 challenge, 3 characterize, 4 measure |
| left_drv_o | output | 2*ROWS | Row r code at bits [2r+1:2r]: 00 float, 01 positive, 10 negative |
| right_drv_o | output | 2*ROWS | Right-side codes, same encoding |
| sample_o | output | 1 | Sample-and-hold strobe |
| measure_o | output | 1 | Boundary measurement strobe |
| iref_code_o | output | 8 | Comparator reference code |
| response_o | output | COLS | Latched response |
| ton_o | output | TON_W | Switch-on time in cycles |

## Verification
All sixteen challenge patterns are applied, and each one uses a different voltage/temperature bin. This separates per-row gating errors from table-indexing errors. It also makes the sample delay sometimes exceed the pulse length, which exposes a missing clamp. Characterization runs cover every row in both polarities. The on-state case must return an all-zero response, which separates a sample taken in the wrong pulse from one taken in the right pulse. Switch-on runs step the switch point from 0 to past saturation. A start pulse during a run, with a different op and challenge, and zero durations cover the remaining corner cases.

// File: rtl/crx_pkg.sv
// Shared types for the crossbar phase sequencer.
// Assumes two-bit drive codes understood by the row multiplexers.
package crx_pkg;
    typedef enum logic [1:0] {
        DRV_FLOAT = 2'b00,
        DRV_POS   = 2'b01,
        DRV_NEG   = 2'b10
    } drv_t;

    typedef enum logic [1:0] {
        OP_CHALRESP = 2'd0,
        OP_CHAR_OFF = 2'd1,
        OP_CHAR_ON  = 2'd2,
        OP_CHAR_TON = 2'd3
    } op_t;

    typedef enum logic [2:0] {
        PH_IDLE      = 3'd0,
        PH_REFRESH   = 3'd1,
        PH_CHALLENGE = 3'd2,
        PH_CHARACT   = 3'd3,
        PH_MEASURE   = 3'd4
    } phase_t;

    typedef enum logic [2:0] {
        DM_FLOAT,
        DM_REFRESH,
        DM_CHAL,
        DM_SEL_POS,
        DM_SEL_NEG
    } mode_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_MAIN,
        S_TON,
        S_MEAS
    } seq_state_t;
endpackage

// File: rtl/crx_env_lut.sv
// Environment table: maps voltage/temperature bins to a reference code
// and a sample delay. Contents are computed from parameters.
// Assumes bins are in range; entry index is volt*TBINS + temp.
module crx_env_lut #(
    parameter int VBINS     = 4,
    parameter int TBINS     = 4,
    parameter int IREF_BASE = 16,
    parameter int IREF_STEP = 12,
    parameter int DLY_BASE  = 0,
    parameter int DLY_TSTEP = 2,
    localparam int VB_W     = $clog2(VBINS),
    localparam int TB_W     = $clog2(TBINS),
    localparam int ENTRIES  = VBINS * TBINS
) (
    input  logic [VB_W-1:0] volt_bin_i,
    input  logic [TB_W-1:0] temp_bin_i,
    output logic [7:0]      iref_o,
    output logic [7:0]      dly_o
);
    logic [7:0] iref_tab [ENTRIES];
    logic [7:0] dly_tab  [ENTRIES];

    for (genvar v = 0; v < VBINS; v++) begin : g_v
        for (genvar t = 0; t < TBINS; t++) begin : g_t
            assign iref_tab[v*TBINS + t] = 8'(IREF_BASE + IREF_STEP * (v*TBINS + t));
            assign dly_tab[v*TBINS + t]  = 8'(DLY_BASE + v + DLY_TSTEP * t);
        end
    end

    // Select the entry for the present environment bins.
    always_comb begin : p_sel
        iref_o = iref_tab[int'(volt_bin_i) * TBINS + int'(temp_bin_i)];
        dly_o  = dly_tab[int'(volt_bin_i) * TBINS + int'(temp_bin_i)];
    end
endmodule

// File: rtl/crx_row_drive.sv
// Per-row drive code generation for left and right multiplexers.
// Assumes mode, challenge and row are stable registered values.
module crx_row_drive
    import crx_pkg::*;
#(
    parameter int ROWS = 4,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  mode_t              mode_i,
    input  logic [ROWS-1:0]    chal_i,
    input  logic [ROW_W-1:0]   row_i,
    output logic [2*ROWS-1:0]  left_o,
    output logic [2*ROWS-1:0]  right_o
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic sel;
        assign sel = (row_i == ROW_W'(r));

        // Decode this row's two codes from the active drive mode.
        always_comb begin : p_code
            left_o[2*r +: 2]  = DRV_FLOAT;
            right_o[2*r +: 2] = DRV_FLOAT;
            case (mode_i)
                DM_REFRESH: right_o[2*r +: 2] = DRV_NEG;
                DM_CHAL:    left_o[2*r +: 2]  = chal_i[r] ? DRV_POS : DRV_FLOAT;
                DM_SEL_POS: left_o[2*r +: 2]  = sel ? DRV_POS : DRV_FLOAT;
                DM_SEL_NEG: left_o[2*r +: 2]  = sel ? DRV_NEG : DRV_FLOAT;
                default:    left_o[2*r +: 2]  = DRV_FLOAT;
            endcase
        end
    end
endmodule

// File: rtl/crx_resp_latch.sv
// Response register: takes the column comparator bits on the sample strobe.
// Assumes comparator outputs are settled in the strobe cycle.
module crx_resp_latch #(
    parameter int COLS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sample_i,
    input  logic [COLS-1:0] cmp_i,
    output logic [COLS-1:0] resp_o
);
    logic [COLS-1:0] resp_q;

    // Capture on strobe, hold otherwise.
    always_ff @(posedge clk) begin : p_cap
        if (!rst_n)        resp_q <= '0;
        else if (sample_i) resp_q <= cmp_i;
    end

    assign resp_o = resp_q;

    a_r4_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_i |=> $stable(resp_q));
endmodule

// File: rtl/crx_seq_fsm.sv
// Phase sequencer: latches run parameters at start, times the pulses,
// places the sample strobe and records switch-on time.
// Assumes CNT_W > TON_W and that start is only taken when idle.
module crx_seq_fsm
    import crx_pkg::*;
#(
    parameter int ROWS  = 4,
    parameter int CNT_W = 8,
    parameter int TON_W = 4,
    localparam int ROW_W = $clog2(ROWS),
    localparam logic [CNT_W-1:0] TON_MAX = CNT_W'((1 << TON_W) - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       op_i,
    input  logic [ROWS-1:0]  challenge_i,
    input  logic [ROW_W-1:0] dev_row_i,
    input  logic [CNT_W-1:0] t_long_i,
    input  logic [CNT_W-1:0] t_chal_i,
    input  logic [CNT_W-1:0] t_probe_i,
    input  logic [7:0]       lut_iref_i,
    input  logic [7:0]       lut_dly_i,
    input  logic             switched_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             sample_o,
    output logic             measure_o,
    output logic [2:0]       phase_o,
    output mode_t            mode_o,
    output logic [ROWS-1:0]  chal_o,
    output logic [ROW_W-1:0] row_o,
    output logic [7:0]       iref_o,
    output logic [TON_W-1:0] ton_o
);
    seq_state_t       state_q;
    op_t              op_q;
    logic [ROWS-1:0]  chal_q;
    logic [ROW_W-1:0] row_q;
    logic [CNT_W-1:0] long_len_q, main_len_q, dly_q, cnt_q;
    logic [7:0]       iref_q;
    logic [TON_W-1:0] ton_q;
    logic             done_q;

    logic [CNT_W-1:0] long_len, main_len, dly_ext, dly_eff;

    function automatic logic [CNT_W-1:0] nz(input logic [CNT_W-1:0] x);
        return (x == '0) ? CNT_W'(1) : x;
    endfunction

    // Effective lengths and clamped sample delay for the run being launched.
    always_comb begin : p_launch
        long_len = nz(t_long_i);
        main_len = (op_i == 2'd0) ? nz(t_chal_i) : nz(t_probe_i);
        dly_ext  = CNT_W'(lut_dly_i);
        dly_eff  = (dly_ext >= main_len) ? main_len - CNT_W'(1) : dly_ext;
    end

    // Phase progression, counters and run-parameter registers.
    always_ff @(posedge clk) begin : p_seq
        if (!rst_n) begin
            state_q    <= S_IDLE;
            op_q       <= OP_CHALRESP;
            chal_q     <= '0;
            row_q      <= '0;
            long_len_q <= CNT_W'(1);
            main_len_q <= CNT_W'(1);
            dly_q      <= '0;
            cnt_q      <= '0;
            iref_q     <= '0;
            ton_q      <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: if (start_i) begin
                    op_q       <= op_t'(op_i);
                    chal_q     <= challenge_i;
                    row_q      <= dev_row_i;
                    long_len_q <= long_len;
                    main_len_q <= main_len;
                    dly_q      <= dly_eff;
                    iref_q     <= lut_iref_i;
                    cnt_q      <= '0;
                    state_q    <= S_PRE;
                end
                S_PRE: begin
                    if (cnt_q == long_len_q - CNT_W'(1)) begin
                        cnt_q   <= '0;
                        state_q <= (op_q == OP_CHAR_TON) ? S_TON : S_MAIN;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                S_MAIN: begin
                    if (cnt_q == main_len_q - CNT_W'(1)) begin
                        cnt_q <= '0;
                        if (op_q == OP_CHALRESP) begin
                            state_q <= S_MEAS;
                        end else begin
                            state_q <= S_IDLE;
                            done_q  <= 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                S_TON: begin
                    if (switched_i || cnt_q == TON_MAX) begin
                        ton_q   <= cnt_q[TON_W-1:0];
                        cnt_q   <= '0;
                        state_q <= S_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                S_MEAS: begin
                    state_q <= S_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Phase code and drive mode from the present state and op.
    always_comb begin : p_decode
        phase_o = PH_IDLE;
        mode_o  = DM_FLOAT;
        case (state_q)
            S_PRE: begin
                phase_o = (op_q == OP_CHALRESP) ? PH_REFRESH : PH_CHARACT;
                case (op_q)
                    OP_CHALRESP: mode_o = DM_REFRESH;
                    OP_CHAR_ON:  mode_o = DM_SEL_POS;
                    default:     mode_o = DM_SEL_NEG;
                endcase
            end
            S_MAIN: begin
                phase_o = (op_q == OP_CHALRESP) ? PH_CHALLENGE : PH_CHARACT;
                case (op_q)
                    OP_CHALRESP: mode_o = DM_CHAL;
                    OP_CHAR_ON:  mode_o = DM_SEL_NEG;
                    default:     mode_o = DM_SEL_POS;
                endcase
            end
            S_TON: begin
                phase_o = PH_CHARACT;
                mode_o  = DM_SEL_POS;
            end
            S_MEAS: phase_o = PH_MEASURE;
            default: begin
                phase_o = PH_IDLE;
                mode_o  = DM_FLOAT;
            end
        endcase
    end

    assign busy_o    = (state_q != S_IDLE);
    assign done_o    = done_q;
    assign sample_o  = (state_q == S_MAIN) && (cnt_q == dly_q);
    assign measure_o = (state_q == S_MEAS);
    assign chal_o    = chal_q;
    assign row_o     = row_q;
    assign iref_o    = iref_q;
    assign ton_o     = ton_q;

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r4_sample_single: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> !sample_o);
    a_r1_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_CHALLENGE && $past(phase_o) != PH_CHALLENGE)
            |-> $past(phase_o) == PH_REFRESH);
    a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(chal_q) && $stable(op_q)));
    a_r7_ton_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TON) |-> (cnt_q <= TON_MAX));
endmodule

// File: rtl/crossbar_phase_seq.sv
// Top of the crossbar phase sequencer: environment table, sequencer,
// row drive decoding and response register.
// Assumes the analog array and sensors are outside this block.
module crossbar_phase_seq
    import crx_pkg::*;
#(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int CNT_W = 8,
    parameter int TON_W = 4,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic [ROWS-1:0]   challenge_i,
    input  logic [ROW_W-1:0]  dev_row_i,
    input  logic [CNT_W-1:0]  t_long_i,
    input  logic [CNT_W-1:0]  t_chal_i,
    input  logic [CNT_W-1:0]  t_probe_i,
    input  logic [1:0]        volt_bin_i,
    input  logic [1:0]        temp_bin_i,
    input  logic [COLS-1:0]   col_cmp_i,
    input  logic              switched_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [2:0]        phase_o,
    output logic [2*ROWS-1:0] left_drv_o,
    output logic [2*ROWS-1:0] right_drv_o,
    output logic              sample_o,
    output logic              measure_o,
    output logic [7:0]        iref_code_o,
    output logic [COLS-1:0]   response_o,
    output logic [TON_W-1:0]  ton_o
);
    logic [7:0]       lut_iref, lut_dly;
    mode_t            mode;
    logic [ROWS-1:0]  chal_q;
    logic [ROW_W-1:0] row_q;

    crx_env_lut u_lut (
        .volt_bin_i (volt_bin_i),
        .temp_bin_i (temp_bin_i),
        .iref_o     (lut_iref),
        .dly_o      (lut_dly)
    );

    crx_seq_fsm #(.ROWS(ROWS), .CNT_W(CNT_W), .TON_W(TON_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .op_i        (op_i),
        .challenge_i (challenge_i),
        .dev_row_i   (dev_row_i),
        .t_long_i    (t_long_i),
        .t_chal_i    (t_chal_i),
        .t_probe_i   (t_probe_i),
        .lut_iref_i  (lut_iref),
        .lut_dly_i   (lut_dly),
        .switched_i  (switched_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .sample_o    (sample_o),
        .measure_o   (measure_o),
        .phase_o     (phase_o),
        .mode_o      (mode),
        .chal_o      (chal_q),
        .row_o       (row_q),
        .iref_o      (iref_code_o),
        .ton_o       (ton_o)
    );

    crx_row_drive #(.ROWS(ROWS)) u_drv (
        .mode_i  (mode),
        .chal_i  (chal_q),
        .row_i   (row_q),
        .left_o  (left_drv_o),
        .right_o (right_drv_o)
    );

    crx_resp_latch #(.COLS(COLS)) u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample_o),
        .cmp_i    (col_cmp_i),
        .resp_o   (response_o)
    );

    a_r6_measure_float: assert property (@(posedge clk) disable iff (!rst_n)
        measure_o |-> (left_drv_o == '0 && right_drv_o == '0));
endmodule

// File: tb/tb_crossbar_phase_seq.sv
module tb_crossbar_phase_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int TONMAX = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [1:0] op_i = '0;
    logic [ROWS-1:0] challenge_i = '0;
    logic [1:0] dev_row_i = '0;
    logic [7:0] t_long_i = '0, t_chal_i = '0, t_probe_i = '0;
    logic [1:0] volt_bin_i = '0, temp_bin_i = '0;
    logic [COLS-1:0] col_cmp_i;
    logic switched_i = 1'b0;
    logic busy_o, done_o, sample_o, measure_o;
    logic [2:0] phase_o;
    logic [2*ROWS-1:0] left_drv_o, right_drv_o;
    logic [7:0] iref_code_o;
    logic [COLS-1:0] response_o;
    logic [3:0] ton_o;

    int n_checks = 0;
    int n_fail = 0;
    logic [COLS-1:0] exp_resp = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crossbar_phase_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .challenge_i(challenge_i), .dev_row_i(dev_row_i),
        .t_long_i(t_long_i), .t_chal_i(t_chal_i), .t_probe_i(t_probe_i),
        .volt_bin_i(volt_bin_i), .temp_bin_i(temp_bin_i),
        .col_cmp_i(col_cmp_i), .switched_i(switched_i),
        .busy_o(busy_o), .done_o(done_o), .phase_o(phase_o),
        .left_drv_o(left_drv_o), .right_drv_o(right_drv_o),
        .sample_o(sample_o), .measure_o(measure_o),
        .iref_code_o(iref_code_o), .response_o(response_o), .ton_o(ton_o)
    );

    // Column comparator stub: weighted sum of positively driven rows vs reference.
    function automatic logic [COLS-1:0] cmp_model(input logic [ROWS-1:0] pos, input int iref);
        logic [COLS-1:0] res;
        for (int j = 0; j < COLS; j++) begin
            int sum = 0;
            for (int r = 0; r < ROWS; r++) if (pos[r]) sum += 20*(r+1) + 9*j;
            res[j] = (sum > iref);
        end
        return res;
    endfunction

    always_comb begin
        logic [ROWS-1:0] pos;
        for (int r = 0; r < ROWS; r++) pos[r] = (left_drv_o[2*r +: 2] == 2'b01);
        col_cmp_i = cmp_model(pos, int'(iref_code_o));
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One run with a cycle-by-cycle comparison against the computed schedule.
    task automatic run_case(input int op, input int chal, input int row, input int tl,
                            input int tc, input int tp, input int v, input int t,
                            input int sw, input bit poke);
        int etl, len, iref, dly, eff, total, ton_len;
        int e_ref, e_chal, e_char, e_smp, e_meas, e_busy, e_ton;
        logic [COLS-1:0] prev_resp;
        etl = (tl == 0) ? 1 : tl;
        len = (op == 0) ? ((tc == 0) ? 1 : tc) : ((tp == 0) ? 1 : tp);
        iref = 16 + 12*(4*v + t);
        dly = v + 2*t;
        eff = (dly >= len) ? len - 1 : dly;
        ton_len = (sw < TONMAX) ? sw : TONMAX;
        total = (op == 0) ? etl + len + 1 : (op == 3) ? etl + ton_len + 1 : etl + len;
        e_ref = 0; e_chal = 0; e_char = 0; e_smp = 0; e_meas = 0; e_busy = 0; e_ton = 0;
        prev_resp = exp_resp;

        @(negedge clk);
        op_i = 2'(op); challenge_i = 4'(chal); dev_row_i = 2'(row);
        t_long_i = 8'(tl); t_chal_i = 8'(tc); t_probe_i = 8'(tp);
        volt_bin_i = 2'(v); temp_bin_i = 2'(t); start_i = 1'b1; switched_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        chk(iref_code_o == 8'(iref), "R5", "reference code", int'(iref_code_o), iref);
        for (int k = 0; k < total; k++) begin
            int exp_ph;
            logic [2*ROWS-1:0] el, er;
            bit exp_smp, exp_meas;
            logic [ROWS-1:0] pos;
            el = '0; er = '0; exp_smp = 0; exp_meas = 0; pos = '0;
            if (op == 0) begin
                if (k < etl) begin exp_ph = 1; er = 8'hAA; end
                else if (k < etl + len) begin
                    exp_ph = 2;
                    for (int r = 0; r < ROWS; r++) if (chal[r]) el[2*r +: 2] = 2'b01;
                end else begin exp_ph = 4; exp_meas = 1; end
            end else begin
                logic [1:0] code;
                exp_ph = 3;
                if (k < etl) code = (op == 2) ? 2'b01 : 2'b10;
                else         code = (op == 2) ? 2'b10 : 2'b01;
                el[2*row +: 2] = code;
            end
            for (int r = 0; r < ROWS; r++) pos[r] = (el[2*r +: 2] == 2'b01);
            if (op != 3 && k == etl + eff) exp_smp = 1;
            if (left_drv_o != el || right_drv_o != er || phase_o != 3'(exp_ph)) begin
                if (op == 0 && k < etl) e_ref++;
                else if (op == 0 && k < etl + len) e_chal++;
                else if (op == 0) e_meas++;
                else if (op == 3) e_ton++;
                else e_char++;
            end
            if (sample_o != exp_smp) e_smp++;
            if (exp_smp && response_o != prev_resp) e_smp++;
            if (exp_smp) exp_resp = cmp_model(pos, iref);
            if (measure_o != exp_meas) e_meas++;
            if (!busy_o || done_o) e_busy++;
            if (poke && k == 1) begin
                start_i = 1'b1; op_i = 2'd3; challenge_i = ~4'(chal);
            end
            if (poke && k == 2) start_i = 1'b0;
            switched_i = (op == 3 && k >= etl && (k - etl) >= sw);
            @(negedge clk);
        end
        switched_i = 1'b0;
        chk(done_o && !busy_o && phase_o == 3'd0 && left_drv_o == '0 && right_drv_o == '0,
            "R8", "done/idle at end", int'(done_o), 1);
        chk(response_o == exp_resp, "R4", "response register", int'(response_o), int'(exp_resp));
        if (op == 0) begin
            chk(e_ref == 0, "R1", "refresh window mismatch cycles", e_ref, 0);
            chk(e_chal == 0, poke ? "R9" : "R2", "challenge window mismatch cycles", e_chal, 0);
            chk(e_meas == 0, "R6", "measure cycle mismatches", e_meas, 0);
        end else if (op == 3) begin
            chk(e_ton == 0, "R7", "switch-on drive mismatch cycles", e_ton, 0);
            chk(ton_o == 4'(ton_len), "R7", "switch-on count", int'(ton_o), ton_len);
            chk(e_meas == 0, "R6", "unexpected measure cycles", e_meas, 0);
        end else begin
            chk(e_char == 0, "R3", "characterization mismatch cycles", e_char, 0);
            chk(e_meas == 0, "R6", "unexpected measure cycles", e_meas, 0);
        end
        chk(e_smp == 0, "R4", "sample strobe mismatches", e_smp, 0);
        chk(e_busy == 0, "R8", "busy/done mismatches in run", e_busy, 0);
        @(negedge clk);
        chk(!done_o, "R8", "done width", int'(done_o), 0);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL R8: watchdog expired cycles=%0d expected below %0d", 50000, 50000);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(!busy_o && !done_o && !sample_o && phase_o == 3'd0 && left_drv_o == '0 &&
            right_drv_o == '0 && response_o == '0 && ton_o == '0,
            "R11", "reset state", int'(busy_o), 0);
        // R1 R2 R5 R6: every challenge with a distinct environment bin
        for (int c = 0; c < 16; c++) run_case(0, c, 0, 3, 5, 4, c % 4, c / 4, 0, 0);
        // R3: every row, both polarities
        for (int r = 0; r < ROWS; r++) begin
            run_case(1, 0, r, 4, 5, 3, r, 3 - r, 0, 0);
            run_case(2, 0, r, 2, 5, 6, 3 - r, r, 0, 0);
        end
        // R7: switch points including saturation
        run_case(3, 0, 1, 3, 5, 4, 0, 0, 0, 0);
        run_case(3, 0, 2, 2, 5, 4, 1, 1, 3, 0);
        run_case(3, 0, 3, 2, 5, 4, 1, 1, 14, 0);
        run_case(3, 0, 0, 2, 5, 4, 1, 1, 15, 0);
        run_case(3, 0, 1, 2, 5, 4, 1, 1, 20, 0);
        // R9: start while busy ignored
        run_case(0, 4'b1010, 0, 3, 6, 4, 2, 1, 0, 1);
        // R10: zero durations behave as one cycle
        run_case(0, 4'b1111, 0, 0, 0, 0, 0, 0, 0, 0);
        run_case(1, 0, 3, 0, 0, 0, 3, 3, 0, 0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule